// File: doc/BRIEF.md
# Register-to-Unit Writer Table with Rollback History

This block tracks, for every architectural destination register, which function unit was most recently issued to produce that register's value. Unit identity is held as a one-hot vector, one bit per function unit. Each register also keeps a short stack of the writers it has superseded, in issue order. A unit that sits in any register's stack has been superseded, and the block reports this as a per-unit flag. That flag tells the commit logic that the unit's result has no architectural name and must not reach the register file.

When a unit finishes, the release port removes it everywhere. When an exception cancels a set of units, the rollback port strips those units out of every register. If a register's current writer was cancelled, the newest surviving superseded writer takes its place. That unit loses its superseded flag, so it is free to write its result back before the exception proceeds.

Issue is a valid/ready transfer. A push happens only on a cycle with both `iss_valid` and `iss_ready` high. The issuer must hold register and unit stable while it waits. Ready is computed combinationally from the addressed register and the control pins. Release and rollback are plain single-cycle control inputs and cannot be refused.

Top module: `fu_writer_table`

## Requirements
- R1: After reset every register's writer field is zero, every superseded flag is zero, and `iss_ready` is high when no release or rollback is presented.
- R2: An accepted issue (`iss_valid` and `iss_ready` high at a rising edge) makes `iss_fu` the writer of register `iss_reg` from the next cycle.
- R3: An accepted issue to a register that already has a writer pushes the old writer onto that register's stack, and the old writer's bit in `fu_nameless` goes high.
- R4: When a register's stack holds HDEPTH entries and it has a current writer, `iss_ready` is low for issues addressed to it, and a presented issue leaves the table unchanged. Other registers stay ready.
- R5: A release mask clears the listed units from every writer field and every stack entry on the next cycle. If a register's writer is released, its writer field becomes zero and its stack is kept.
- R6: A rollback removes every cancelled unit from all writer fields and stacks. For each register whose writer was cancelled, the newest stack entry that was not cancelled becomes the writer and leaves the stack. If no such entry exists, the writer field becomes zero.
- R7: Rollback keeps the issue order of surviving stack entries. Repeated rollbacks therefore restore writers newest first, and a promoted unit's `fu_nameless` bit falls.
- R8: `iss_ready` is low in any cycle in which `rb_valid` is high or `rel_mask` is non-zero.
- R9: `wr_cur` bits [r*NFU +: NFU] give register r's writer, bit u set meaning unit u. At most one bit in each field is set.
- R10: An accepted issue to a register with no current writer pushes nothing, and `fu_nameless` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_reg | input | $clog2(NREG) | Destination register of the issue |
| iss_fu | input | NFU | One-hot unit being issued |
| rel_mask | input | NFU | Units completing or released this cycle |
| rb_valid | input | 1 | Apply rollback this cycle |
| rb_cancel | input | NFU | Units cancelled by the rollback |
| wr_cur | output | NREG*NFU | Current writer of every register, one-hot per field |
| fu_nameless | output | NFU | Unit is held in some register's history (commit blocked) |

## Verification
The bench builds the table with NREG=4, NFU=4 and HDEPTH=2. With these values three issues to one register are enough to fill its stack, so the stall case is reached quickly. Four units are also enough to cancel two stack levels at once and to watch promotion skip a cancelled entry. Two more short sequences are covered: a register whose writer is released while its stack survives, and alternating rollbacks that unwind a stack newest first.

// File: rtl/fu_wt_pkg.sv
package fu_wt_pkg;
  // Next-state action chosen for one register slot
  typedef enum logic [1:0] {
    ACT_HOLD,   // nothing touches this register
    ACT_PUSH,   // accepted issue: old writer moves to the stack
    ACT_TRIM,   // release/rollback removes units, no promotion
    ACT_POP     // rollback cancelled the writer: newest survivor promoted
  } slot_act_e;
endpackage

// File: rtl/fu_wt_slot.sv
module fu_wt_slot
  import fu_wt_pkg::*;
#(
  parameter int NFU    = 8,
  parameter int HDEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_hit,
  input  logic [NFU-1:0] iss_fu,
  input  logic [NFU-1:0] rel_mask,
  input  logic           rb_en,
  input  logic [NFU-1:0] rb_mask,
  output logic [NFU-1:0] cur_o,
  output logic [NFU-1:0] hist_or_o,
  output logic           full_o
);
  localparam int CW = $clog2(HDEPTH + 1);

  logic [NFU-1:0] cur_q, cur_d;
  logic [NFU-1:0] hist_q [HDEPTH];
  logic [NFU-1:0] hist_d [HDEPTH];
  logic [NFU-1:0] kept   [HDEPTH];
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [NFU-1:0] kill;
  logic [NFU-1:0] top_keep;
  logic [HDEPTH-1:0] keep;
  int             rank [HDEPTH];
  int             nkeep;
  slot_act_e      act;

  assign kill = rel_mask | (rb_en ? rb_mask : '0);

  // Compact surviving stack entries, oldest at index 0
  always_comb begin
    nkeep = 0;
    for (int i = 0; i < HDEPTH; i++) begin
      keep[i] = (CW'(i) < cnt_q) && ((hist_q[i] & kill) == '0);
      rank[i] = 0;
      for (int k = 0; k < i; k++) rank[i] = rank[i] + int'(keep[k]);
      nkeep = nkeep + int'(keep[i]);
    end
    for (int j = 0; j < HDEPTH; j++) begin
      kept[j] = '0;
      for (int i = 0; i < HDEPTH; i++)
        if (keep[i] && rank[i] == j) kept[j] = hist_q[i];
    end
    top_keep = '0;
    for (int j = 0; j < HDEPTH; j++)
      if (j + 1 == nkeep) top_keep = kept[j];
  end

  always_comb begin
    if (kill != '0) begin
      if (rb_en && ((cur_q & rb_mask) != '0) && nkeep > 0) act = ACT_POP;
      else                                                 act = ACT_TRIM;
    end else if (iss_hit) begin
      act = ACT_PUSH;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_comb begin
    cur_d = cur_q;
    cnt_d = cnt_q;
    for (int j = 0; j < HDEPTH; j++) hist_d[j] = hist_q[j];
    case (act)
      ACT_PUSH: begin
        cur_d = iss_fu;
        if (cur_q != '0) begin
          for (int j = 0; j < HDEPTH; j++)
            if (CW'(j) == cnt_q) hist_d[j] = cur_q;
          cnt_d = cnt_q + 1'b1;
        end
      end
      ACT_TRIM: begin
        cur_d = cur_q & ~kill;
        for (int j = 0; j < HDEPTH; j++) hist_d[j] = kept[j];
        cnt_d = CW'(nkeep);
      end
      ACT_POP: begin
        cur_d = top_keep;
        for (int j = 0; j < HDEPTH; j++)
          hist_d[j] = (j + 1 < nkeep) ? kept[j] : '0;
        cnt_d = CW'(nkeep - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      cnt_q <= '0;
      for (int j = 0; j < HDEPTH; j++) hist_q[j] <= '0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
      for (int j = 0; j < HDEPTH; j++) hist_q[j] <= hist_d[j];
    end
  end

  always_comb begin
    hist_or_o = '0;
    for (int j = 0; j < HDEPTH; j++) hist_or_o = hist_or_o | hist_q[j];
  end

  assign cur_o  = cur_q;
  assign full_o = (cnt_q == CW'(HDEPTH)) && (cur_q != '0);

  a_r9_cur_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cur_q));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(HDEPTH));
  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_hit && kill == '0 && cur_q != '0) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r10_empty_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_hit && kill == '0 && cur_q == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/fu_wt_or_reduce.sv
module fu_wt_or_reduce #(
  parameter int NREG = 8,
  parameter int NFU  = 8
) (
  input  logic [NREG*NFU-1:0] vec_i,
  output logic [NFU-1:0]      any_o
);
  always_comb begin
    any_o = '0;
    for (int r = 0; r < NREG; r++) any_o = any_o | vec_i[r*NFU +: NFU];
  end
endmodule

// File: rtl/fu_writer_table.sv
module fu_writer_table #(
  parameter int NREG   = 8,
  parameter int NFU    = 8,
  parameter int HDEPTH = 2,
  localparam int RW    = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  output logic                iss_ready,
  input  logic [RW-1:0]       iss_reg,
  input  logic [NFU-1:0]      iss_fu,
  input  logic [NFU-1:0]      rel_mask,
  input  logic                rb_valid,
  input  logic [NFU-1:0]      rb_cancel,
  output logic [NREG*NFU-1:0] wr_cur,
  output logic [NFU-1:0]      fu_nameless
);
  logic [NREG-1:0]     full;
  logic [NREG*NFU-1:0] hist_any;
  logic                iss_take;

  assign iss_ready = !rb_valid && (rel_mask == '0) && !full[iss_reg];
  assign iss_take  = iss_valid && iss_ready;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit = iss_take && (iss_reg == RW'(r));
    fu_wt_slot #(.NFU(NFU), .HDEPTH(HDEPTH)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_hit   (hit),
      .iss_fu    (iss_fu),
      .rel_mask  (rel_mask),
      .rb_en     (rb_valid),
      .rb_mask   (rb_cancel),
      .cur_o     (wr_cur[r*NFU +: NFU]),
      .hist_or_o (hist_any[r*NFU +: NFU]),
      .full_o    (full[r])
    );

    a_r2_issue_lands: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (wr_cur[r*NFU +: NFU] == $past(iss_fu)));
    a_r6_cancel_gone: assert property (@(posedge clk) disable iff (!rst_n)
      rb_valid |=> ((wr_cur[r*NFU +: NFU] & $past(rb_cancel)) == '0));
  end

  fu_wt_or_reduce #(.NREG(NREG), .NFU(NFU)) u_or (
    .vec_i (hist_any),
    .any_o (fu_nameless)
  );

  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_mask != '0) |=> ((fu_nameless & $past(rel_mask)) == '0));
  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && full[iss_reg]) |-> !iss_ready);
endmodule

// File: tb/fu_writer_table_bench.sv
module fu_writer_table_bench;
  localparam int NREG = 4, NFU = 4, HDEPTH = 2;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_ready;
  logic [1:0] iss_reg = 0;
  logic [3:0] iss_fu = 0, rel_mask = 0, rb_cancel = 0, fu_nameless;
  logic rb_valid = 0;
  logic [15:0] wr_cur;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fu_writer_table #(.NREG(NREG), .NFU(NFU), .HDEPTH(HDEPTH)) u_fu_writer_table (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_reg(iss_reg), .iss_fu(iss_fu), .rel_mask(rel_mask),
    .rb_valid(rb_valid), .rb_cancel(rb_cancel), .wr_cur(wr_cur),
    .fu_nameless(fu_nameless));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(int r, logic [3:0] u);
    @(negedge clk);
    iss_valid = 1; iss_reg = 2'(r); iss_fu = u;
    @(negedge clk);
    iss_valid = 0;
  endtask

  task automatic release_units(logic [3:0] m);
    @(negedge clk);
    rel_mask = m;
    #1 chk("R8 ready low on release", 16'(iss_ready), 16'h0);
    @(negedge clk);
    rel_mask = 0;
  endtask

  task automatic rollback(logic [3:0] m);
    @(negedge clk);
    rb_valid = 1; rb_cancel = m;
    #1 chk("R8 ready low on rollback", 16'(iss_ready), 16'h0);
    @(negedge clk);
    rb_valid = 0; rb_cancel = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 writers empty", wr_cur, 16'h0);
    chk("R1 nameless empty", 16'(fu_nameless), 16'h0);
    chk("R1 ready", 16'(iss_ready), 16'h1);
  endtask

  task automatic t_fill_and_stall;
    issue(1, 4'b0001);
    chk("R2 R10 first writer", wr_cur, 16'h0010);
    chk("R10 no push", 16'(fu_nameless), 16'h0);
    issue(1, 4'b0010);
    chk("R3 second writer", wr_cur, 16'h0020);
    chk("R3 old writer superseded", 16'(fu_nameless), 16'h1);
    issue(1, 4'b0100);
    chk("R9 third writer field", wr_cur, 16'h0040);
    chk("R3 stack two deep", 16'(fu_nameless), 16'h3);
    @(negedge clk);
    iss_valid = 1; iss_reg = 1; iss_fu = 4'b1000;
    #1 chk("R4 full register stalls", 16'(iss_ready), 16'h0);
    @(negedge clk);
    chk("R4 stalled issue ignored", wr_cur, 16'h0040);
    iss_valid = 0; iss_reg = 2;
    #1 chk("R4 other register ready", 16'(iss_ready), 16'h1);
  endtask

  task automatic t_rollback_release;
    rollback(4'b0100);
    chk("R6 promote newest survivor", wr_cur, 16'h0020);
    chk("R7 promoted unit unblocked", 16'(fu_nameless), 16'h1);
    release_units(4'b0001);
    chk("R5 release from stack", 16'(fu_nameless), 16'h0);
    chk("R5 writer untouched", wr_cur, 16'h0020);
    issue(1, 4'b0100);
    issue(2, 4'b1000);
    chk("R9 two registers", wr_cur, 16'h0840);
    chk("R3 stack after reissue", 16'(fu_nameless), 16'h2);
    release_units(4'b0100);
    chk("R5 writer released", wr_cur, 16'h0800);
    chk("R5 stack kept", 16'(fu_nameless), 16'h2);
    rollback(4'b1000);
    chk("R6 no survivor empties", wr_cur, 16'h0000);
    chk("R6 untouched stack kept", 16'(fu_nameless), 16'h2);
    release_units(4'b0010);
    chk("R5 last stack entry released", 16'(fu_nameless), 16'h0);
  endtask

  task automatic t_deep_rollback;
    issue(3, 4'b0001);
    issue(3, 4'b0010);
    issue(3, 4'b0100);
    chk("R3 register 3 full", wr_cur, 16'h4000);
    rollback(4'b0110);
    chk("R6 skip cancelled entry", wr_cur, 16'h1000);
    chk("R6 stack emptied", 16'(fu_nameless), 16'h0);
    issue(3, 4'b0010);
    issue(3, 4'b0100);
    rollback(4'b0100);
    chk("R7 newest first", wr_cur, 16'h2000);
    chk("R7 older still blocked", 16'(fu_nameless), 16'h1);
    rollback(4'b0010);
    chk("R7 then oldest", wr_cur, 16'h1000);
    chk("R7 all unblocked", 16'(fu_nameless), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_fill_and_stall;
    t_rollback_release;
    t_deep_rollback;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule